// File: doc/BRIEF.md
# PoE classification event tracker

This block is the digital sequencer of a single-signature powered-device front end. External comparators turn the port voltage into a few window flags. The block synchronises and debounces those flags and steps through four phases: detect, class, mark and powered. Each class probe that the power source issues is counted, up to five. The first probe is timed, and the block records whether the source uses the longer first event of the extended vendor scheme or the timing of a standard IEEE 802.3bt source.

From the phase, the block drives five enables: the detection signature load, the classification current sink, the low-resistance mark load, the hot-swap gate and the power-good pull-down. An auxiliary-supply sense input overrides everything else. An over-temperature input removes the gate drive and blocks classification. Thresholds, current sources and the charge pump stay in the analog domain and appear here only as flag inputs.

Top module: `pd_class_tracker`

## Requirements
- R1: The `phase` output is encoded as 0 = detect, 1 = class, 2 = mark, 3 = powered, and reset leaves it at detect. A filtered class-window flag moves the block from detect or mark into class, and a filtered mark-window flag moves it from class into mark. The signature load is enabled only in detect and the class sink only in class.
- R2: `event_count` increments by one on every entry into class and saturates at MAX_EVENTS (5 by default).
- R3: A filtered below-reset flag seen in class or mark returns the block to detect and clears `event_count` and `ext_source`.
- R4: The block enters powered when the above-turn-on flag is set and stays there while the above-turn-off flag holds, even after the turn-on flag has dropped. It then returns to detect with `event_count` cleared. `gate_en` is high only in powered.
- R5: `pg_pull_low` is 1 from reset and through detect, class, mark and inrush. It drops to 0 once the gate is on and the gate-charged flag is seen, and it returns to 1 when the gate turns off.
- R6: While the auxiliary-sense flag is set, `gate_en`, `sig_load_en`, `class_sink_en`, `mark_load_en` and `pg_pull_low` are all 0, the phase is detect and the counter is cleared. This overrides every other input, including a class window that rises in the same cycle.
- R7: While the over-temperature flag is set, `gate_en` and `class_sink_en` are 0 and no class entry takes place. Entry into powered still occurs, but the gate stays off until the flag clears.
- R8: The mark load is enabled only in mark. At most one of the signature, class-sink and mark-load enables is high in any cycle.
- R9: `ext_source` is set when the first class event lasts at least EXT_THRESH clock cycles, measured as filtered cycles in class. It stays 0 when the first event is shorter, and later events do not change it.
- R10: Each input flag passes two synchronising flops and must then hold a new value for DEB_CYCLES consecutive samples before it takes effect. A shorter pulse is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| port_class_win | input | 1 | Port voltage is in the classification window |
| port_mark_win | input | 1 | Port voltage is in the mark window |
| port_below_reset | input | 1 | Port voltage is below the reset threshold |
| port_above_on | input | 1 | Port voltage is above the hot-swap turn-on level |
| port_above_off | input | 1 | Port voltage is above the hot-swap turn-off level |
| gate_charged | input | 1 | Gate is fully enhanced above the source pin |
| aux_sense | input | 1 | Auxiliary supply is present |
| over_temp | input | 1 | Junction over-temperature |
| sig_load_en | output | 1 | Enable for the detection signature load |
| class_sink_en | output | 1 | Enable for the classification current sink |
| mark_load_en | output | 1 | Enable for the mark-phase low-resistance load |
| gate_en | output | 1 | Hot-swap gate drive enable |
| pg_pull_low | output | 1 | Power-good open-drain pull-down (1 = pulled low) |
| event_count | output | $clog2(MAX_EVENTS+1) | Class events counted since detect |
| ext_source | output | 1 | Source uses the extended long-first-event scheme |
| phase | output | 2 | Current phase, encoded as in R1 |

## Verification
Two functions can act in the same cycle: auxiliary override against classification entry, and over-temperature shutdown against entry into powered. The bench drives the auxiliary flag and a class-window port level on the same clock edge. Both pass the same filter depth, so they reach the sequencer together, and the bench then requires detect, a zero count and every load off. It also raises the port above turn-on while over-temperature is set. It expects the powered phase with the gate off, and the gate to come on once the fault clears.

// File: rtl/pd_class_pkg.sv
package pd_class_pkg;

    typedef enum logic [1:0] {
        PH_DETECT = 2'd0,
        PH_CLASS  = 2'd1,
        PH_MARK   = 2'd2,
        PH_POWER  = 2'd3
    } phase_e;

    // positions of the input flags in the filtered vector
    localparam int FL_CLASS   = 0;
    localparam int FL_MARK    = 1;
    localparam int FL_RESET   = 2;
    localparam int FL_ON      = 3;
    localparam int FL_OFF     = 4;
    localparam int FL_CHARGED = 5;
    localparam int FL_AUX     = 6;
    localparam int FL_OT      = 7;
    localparam int NUM_FLAGS  = 8;

endpackage

// File: rtl/flag_filter.sv
module flag_filter #(
    parameter int DEB_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic filt
);
    localparam int DBW = (DEB_CYCLES < 2) ? 1 : $clog2(DEB_CYCLES + 1);

    typedef struct packed {
        logic           s1;
        logic           s2;
        logic           out;
        logic [DBW-1:0] cnt;
    } flt_t;

    flt_t q, d;

    always_comb begin
        d    = q;
        d.s1 = raw;
        d.s2 = q.s1;
        if (q.s2 == q.out) begin
            d.cnt = '0;
        end else if (q.cnt == DBW'(DEB_CYCLES - 1)) begin
            d.out = q.s2;
            d.cnt = '0;
        end else begin
            d.cnt = q.cnt + DBW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign filt = q.out;

    // R10: the filtered value only changes after the debounce count completes
    assert_filter_wait_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (q.out != $past(q.out)) |-> ($past(q.cnt) == DBW'(DEB_CYCLES - 1)));

endmodule

// File: rtl/event_fsm.sv
module event_fsm
    import pd_class_pkg::*;
#(
    parameter int MAX_EVENTS = 5,
    parameter int EXT_THRESH = 59000,
    localparam int CW = $clog2(MAX_EVENTS + 1),
    localparam int TW = $clog2(EXT_THRESH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          class_win,
    input  logic          mark_win,
    input  logic          below_reset,
    input  logic          above_on,
    input  logic          above_off,
    input  logic          aux,
    input  logic          ot,
    output phase_e        phase_q,
    output logic [CW-1:0] count_q,
    output logic          ext_q
);
    typedef struct packed {
        phase_e        phase;
        logic [CW-1:0] count;
        logic [TW-1:0] timer;
        logic          ext;
    } fsm_t;

    fsm_t q, d;
    logic [CW-1:0] bumped;

    assign bumped = (q.count == CW'(MAX_EVENTS)) ? q.count : q.count + CW'(1);

    always_comb begin
        d = q;
        if (aux) begin
            d.phase = PH_DETECT;
            d.count = '0;
            d.timer = '0;
            d.ext   = 1'b0;
        end else begin
            unique case (q.phase)
                PH_DETECT: begin
                    if (above_on) begin
                        d.phase = PH_POWER;
                    end else if (class_win && !ot) begin
                        d.phase = PH_CLASS;
                        d.count = bumped;
                        d.timer = TW'(1);
                    end
                end
                PH_CLASS: begin
                    if (q.timer != TW'(EXT_THRESH)) d.timer = q.timer + TW'(1);
                    if (below_reset) begin
                        d.phase = PH_DETECT;
                        d.count = '0;
                        d.timer = '0;
                        d.ext   = 1'b0;
                    end else if (above_on || mark_win) begin
                        d.phase = above_on ? PH_POWER : PH_MARK;
                        if (q.count == CW'(1)) d.ext = (q.timer == TW'(EXT_THRESH));
                    end
                end
                PH_MARK: begin
                    if (below_reset) begin
                        d.phase = PH_DETECT;
                        d.count = '0;
                        d.timer = '0;
                        d.ext   = 1'b0;
                    end else if (above_on) begin
                        d.phase = PH_POWER;
                    end else if (class_win && !ot) begin
                        d.phase = PH_CLASS;
                        d.count = bumped;
                        d.timer = TW'(1);
                    end
                end
                default: begin
                    if (!above_off) begin
                        d.phase = PH_DETECT;
                        d.count = '0;
                        d.timer = '0;
                        d.ext   = 1'b0;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.phase <= PH_DETECT;
            q.count <= '0;
            q.timer <= '0;
            q.ext   <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign phase_q = q.phase;
    assign count_q = q.count;
    assign ext_q   = q.ext;

    // R2: the counter either steps by one or clears
    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.count != $past(q.count)) |-> (q.count == $past(q.count) + CW'(1) || q.count == '0));

    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        q.count <= CW'(MAX_EVENTS));

    // R9: the source type is decided only at the end of the first class event
    assert_ext_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.ext) |-> ($past(q.phase) == PH_CLASS && $past(q.count) == CW'(1)));

    // R6: the auxiliary supply forces detect with a clear counter
    assert_aux_detect_R6: assert property (@(posedge clk) disable iff (!rst_n)
        aux |=> (q.phase == PH_DETECT && q.count == '0));

endmodule

// File: rtl/hotswap_ctrl.sv
module hotswap_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic in_power,
    input  logic aux,
    input  logic ot,
    input  logic charged,
    output logic gate_q,
    output logic pg_pull_low
);
    typedef struct packed {
        logic gate;
        logic pg_ok;
    } hs_t;

    hs_t q, d;

    always_comb begin
        d.gate  = in_power && !aux && !ot;
        d.pg_ok = q.gate && (q.pg_ok || charged);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign gate_q      = q.gate;
    assign pg_pull_low = !aux && !q.pg_ok;

    // R6: the auxiliary supply removes the gate drive
    assert_aux_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        aux |=> !q.gate);

    // R7: over-temperature removes the gate drive
    assert_ot_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ot |=> !q.gate);

    // R5: power-good only releases behind an enabled gate
    assert_pg_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        q.pg_ok |-> $past(q.gate));

endmodule

// File: rtl/pd_class_tracker.sv
module pd_class_tracker
    import pd_class_pkg::*;
#(
    parameter int DEB_CYCLES = 8,
    parameter int EXT_THRESH = 59000,
    parameter int MAX_EVENTS = 5
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              port_class_win,
    input  logic                              port_mark_win,
    input  logic                              port_below_reset,
    input  logic                              port_above_on,
    input  logic                              port_above_off,
    input  logic                              gate_charged,
    input  logic                              aux_sense,
    input  logic                              over_temp,
    output logic                              sig_load_en,
    output logic                              class_sink_en,
    output logic                              mark_load_en,
    output logic                              gate_en,
    output logic                              pg_pull_low,
    output logic [$clog2(MAX_EVENTS+1)-1:0]   event_count,
    output logic                              ext_source,
    output logic [1:0]                        phase
);
    localparam int CW = $clog2(MAX_EVENTS + 1);

    logic [NUM_FLAGS-1:0] raw_vec, flt_vec;
    phase_e               ph;
    logic [CW-1:0]        cnt;
    logic                 ext;

    assign raw_vec[FL_CLASS]   = port_class_win;
    assign raw_vec[FL_MARK]    = port_mark_win;
    assign raw_vec[FL_RESET]   = port_below_reset;
    assign raw_vec[FL_ON]      = port_above_on;
    assign raw_vec[FL_OFF]     = port_above_off;
    assign raw_vec[FL_CHARGED] = gate_charged;
    assign raw_vec[FL_AUX]     = aux_sense;
    assign raw_vec[FL_OT]      = over_temp;

    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flt
        flag_filter #(.DEB_CYCLES(DEB_CYCLES)) u_flt (
            .clk  (clk),
            .rst_n(rst_n),
            .raw  (raw_vec[g]),
            .filt (flt_vec[g])
        );
    end

    event_fsm #(.MAX_EVENTS(MAX_EVENTS), .EXT_THRESH(EXT_THRESH)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .class_win  (flt_vec[FL_CLASS]),
        .mark_win   (flt_vec[FL_MARK]),
        .below_reset(flt_vec[FL_RESET]),
        .above_on   (flt_vec[FL_ON]),
        .above_off  (flt_vec[FL_OFF]),
        .aux        (flt_vec[FL_AUX]),
        .ot         (flt_vec[FL_OT]),
        .phase_q    (ph),
        .count_q    (cnt),
        .ext_q      (ext)
    );

    hotswap_ctrl u_hs (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_power   (ph == PH_POWER),
        .aux        (flt_vec[FL_AUX]),
        .ot         (flt_vec[FL_OT]),
        .charged    (flt_vec[FL_CHARGED]),
        .gate_q     (gate_en),
        .pg_pull_low(pg_pull_low)
    );

    assign sig_load_en   = (ph == PH_DETECT) && !flt_vec[FL_AUX];
    assign class_sink_en = (ph == PH_CLASS) && !flt_vec[FL_AUX] && !flt_vec[FL_OT];
    assign mark_load_en  = (ph == PH_MARK) && !flt_vec[FL_AUX];
    assign event_count   = cnt;
    assign ext_source    = ext;
    assign phase         = ph;

    // R8: the three port loads never overlap
    assert_loads_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sig_load_en, class_sink_en, mark_load_en}));

    // R4: the gate is only driven in the powered phase
    assert_gate_power_R4: assert property (@(posedge clk) disable iff (!rst_n)
        gate_en |-> $past(ph == PH_POWER));

endmodule

// File: tb/pd_class_tracker_bench.sv
`timescale 1ns/1ps
module pd_class_tracker_bench;
    localparam int DEB = 3;
    localparam int THR = 30;
    localparam int MAXE = 5;
    localparam int SETTLE = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    int   vport = 5;
    logic charged = 1'b0, aux = 1'b0, ot = 1'b0;
    logic cls_w, mrk_w, rst_w, on_w, off_w;
    logic sig, csink, mload, gate, pgl, ext;
    logic [2:0] cnt;
    logic [1:0] ph;
    int checks = 0, failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    // comparator model of the port voltage (volts)
    assign cls_w = (vport >= 13) && (vport <= 20);
    assign mrk_w = (vport >= 6) && (vport <= 10);
    assign rst_w = (vport < 4);
    assign on_w  = (vport >= 36);
    assign off_w = (vport >= 31);

    pd_class_tracker #(.DEB_CYCLES(DEB), .EXT_THRESH(THR), .MAX_EVENTS(MAXE)) u_pd_class_tracker (
        .clk(clk), .rst_n(rst_n),
        .port_class_win(cls_w), .port_mark_win(mrk_w), .port_below_reset(rst_w),
        .port_above_on(on_w), .port_above_off(off_w), .gate_charged(charged),
        .aux_sense(aux), .over_temp(ot),
        .sig_load_en(sig), .class_sink_en(csink), .mark_load_en(mload),
        .gate_en(gate), .pg_pull_low(pgl), .event_count(cnt),
        .ext_source(ext), .phase(ph)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic class_event(input int len, input int idx);
        vport = 17;
        step(SETTLE);
        chk(ph, 1, "R1 phase in class");
        chk(csink, 1, "R1 class sink on");
        chk(cnt, (idx < MAXE) ? idx : MAXE, "R2 event count");
        step(len - SETTLE);
        vport = 8;
        step(SETTLE);
        chk(ph, 2, "R1 phase in mark");
        chk(mload, 1, "R8 mark load on");
        chk(sig, 0, "R8 signature off in mark");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(SETTLE);
        chk(ph, 0, "R1 reset phase");
        chk(sig, 1, "R1 reset signature on");
        chk(cnt, 0, "R2 reset count");
        chk(gate, 0, "R4 reset gate");
        chk(pgl, 1, "R5 reset power-good low");

        // R10: short class pulse ignored
        vport = 17;
        step(2);
        vport = 5;
        step(SETTLE);
        chk(ph, 0, "R10 glitch phase");
        chk(cnt, 0, "R10 glitch count");

        // sweep of event counts, first event long for odd n
        for (int n = 1; n <= 6; n++) begin
            vport = 5;
            step(SETTLE);
            for (int i = 1; i <= n; i++)
                class_event((i == 1 && (n % 2 == 1)) ? THR + 15 : THR - 16, i);
            chk(ext, n % 2, "R9 source type");
            vport = 48;
            step(SETTLE);
            chk(ph, 3, "R4 powered");
            chk(gate, 1, "R4 gate on");
            chk(pgl, 1, "R5 power-good low during inrush");
            chk(cnt, (n < MAXE) ? n : MAXE, "R2 count kept when powered");
            charged = 1'b1;
            step(SETTLE);
            chk(pgl, 0, "R5 power-good released");
            vport = 33;
            step(SETTLE);
            chk(gate, 1, "R4 hysteresis keeps gate");
            vport = 0;
            charged = 1'b0;
            step(SETTLE);
            chk(ph, 0, "R4 back to detect");
            chk(gate, 0, "R4 gate off");
            chk(cnt, 0, "R4 count cleared");
            chk(pgl, 1, "R5 power-good low again");
        end

        // R3: reset from mark
        vport = 5;
        step(SETTLE);
        class_event(THR + 15, 1);
        chk(ext, 1, "R9 long first event");
        vport = 3;
        step(SETTLE);
        chk(ph, 0, "R3 reset phase");
        chk(cnt, 0, "R3 reset count");
        chk(ext, 0, "R3 reset source type");

        // R9: later long event does not set the type
        vport = 5;
        step(SETTLE);
        class_event(THR - 16, 1);
        class_event(THR + 15, 2);
        chk(ext, 0, "R9 later event ignored");
        vport = 3;
        step(SETTLE);

        // R7: over-temperature blocks class and gate
        vport = 5;
        step(SETTLE);
        ot = 1'b1;
        vport = 17;
        step(SETTLE + 3);
        chk(ph, 0, "R7 no class entry");
        chk(csink, 0, "R7 sink off");
        chk(cnt, 0, "R7 count unchanged");
        ot = 1'b0;
        step(SETTLE);
        chk(ph, 1, "R7 class after fault");
        chk(cnt, 1, "R7 count after fault");
        vport = 48;
        charged = 1'b1;
        step(SETTLE);
        chk(pgl, 0, "R5 power-good released before fault");
        ot = 1'b1;
        step(SETTLE);
        chk(gate, 0, "R7 gate off on fault");
        chk(pgl, 1, "R7 power-good low on fault");
        ot = 1'b0;
        step(SETTLE);
        chk(gate, 1, "R7 gate back");
        chk(pgl, 0, "R7 power-good back");

        // R6: auxiliary override while powered
        aux = 1'b1;
        step(SETTLE);
        chk(gate, 0, "R6 gate off");
        chk(pgl, 0, "R6 power-good released");
        chk(sig, 0, "R6 signature off");
        chk(ph, 0, "R6 phase detect");
        chk(cnt, 0, "R6 count cleared");
        vport = 17;
        step(SETTLE);
        chk(csink, 0, "R6 class disabled");
        chk(cnt, 0, "R6 no count under aux");
        aux = 1'b0;
        charged = 1'b0;
        step(SETTLE);
        chk(ph, 1, "R6 class after aux");
        vport = 0;
        step(SETTLE);

        // same-cycle: aux and class window together
        vport = 5;
        step(SETTLE);
        aux = 1'b1;
        vport = 17;
        step(SETTLE + 3);
        chk(ph, 0, "R6 aux beats class entry");
        chk(cnt, 0, "R6 aux beats count");
        chk(csink | sig | mload, 0, "R6 all loads off");
        aux = 1'b0;
        vport = 0;
        step(SETTLE);

        // same-cycle: over-temperature and turn-on together
        vport = 5;
        step(SETTLE);
        ot = 1'b1;
        vport = 48;
        step(SETTLE);
        chk(ph, 3, "R7 powered under fault");
        chk(gate, 0, "R7 gate held off");
        ot = 1'b0;
        step(SETTLE);
        chk(gate, 1, "R7 gate after fault clears");

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule